// File: doc/BRIEF.md
# Filter Host Register Block with Role-Gated System Access

This block is the host-facing register front end of one packet filter device. A host reaches it through two selects. The chip select addresses a window of four chip registers placed at the parameter `CHIP_BASE`. The system select addresses a small bank of system registers. The filtering engine sits outside this block. It hands finished results over a one-cycle push strobe into a four-entry result queue, and the host drains that queue through the chip registers.

The chip role register resets to a slave value. While it holds any nonzero value, every system-select access is refused: writes are discarded, and reads return zero with an error pulse. Software must load zero, which means master, before the system registers respond. When two devices are chained, exactly one of them is loaded as master. A device used alone is loaded as master. An interrupt output rises when a result lands in an empty queue. A status read lowers it only once the queue has been fully drained.

Top module: `filt_host_regs`

## Requirements
- R1: After reset the role register reads 1 (slave), the queue is empty, and `irq_o`, `rvalid_o` and `err_o` are low.
- R2: A chip-select access hits only when `addr_i - CHIP_BASE` is 0 to 3. The offsets are 0 status, 1 result data, 2 role and 3 version. A read outside that window gives `rvalid_o` low.
- R3: A read issued in one cycle presents `rdata_o` with `rvalid_o` high in the next cycle. Whenever `rvalid_o` is low, `rdata_o` is 0.
- R4: A status read returns bit 0 = 1 when the queue holds at least one result, and returns 0 otherwise. All other bits are 0.
- R5: A result data read pops the oldest result in push order. A read of an empty queue returns 0 and leaves the queue empty. A push into a full queue of 4 is discarded.
- R6: The role register is written and read at offset 2. The value 0 means master and any other value means slave.
- R7: The version register always reads `VERSION` (default 3), and writes to offsets 3, 0 and 1 change no register.
- R8: While the role is slave, system-select writes are discarded. System-select reads return `rdata_o` = 0 with `rvalid_o` low and `err_o` high for exactly one cycle.
- R9: While the role is master, a system-select write stores `wdata_i` in register `addr_i[1:0]`, and a later read returns it with `rvalid_o` high and `err_o` low.
- R10: A push into an empty queue raises `irq_o` in the next cycle.
- R11: A status read lowers `irq_o` in the next cycle only if the queue is empty at that read. With results pending, `irq_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_chip_i | input | 1 | Chip register select |
| cs_sys_i | input | 1 | System register select |
| addr_i | input | AW (8) | Access address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW (16) | Write data |
| rdata_o | output | DW (16) | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Refused system read, one-cycle pulse |
| res_push_i | input | 1 | Result push strobe from the filter engine |
| res_data_i | input | DW (16) | Result word |
| irq_o | output | 1 | Result interrupt, active high |

## Verification
The assertions assume that the host never raises both selects in the same cycle and never asserts `rd_i` and `wr_i` together. They also assume that strobes last a single cycle, so that each access is counted once. The random stimulus draws one operation per access slot, drives exactly one select with exactly one strobe, and releases everything before the next slot. Pushes and host reads are therefore never simultaneous, and a push into a full queue is always a plain discard.

// File: rtl/filt_hreg_pkg.sv
package filt_hreg_pkg;
  typedef enum logic [1:0] {
    OFF_STAT = 2'd0,
    OFF_DATA = 2'd1,
    OFF_ROLE = 2'd2,
    OFF_VER  = 2'd3
  } chip_off_e;
endpackage

// File: rtl/filt_res_fifo.sv
module filt_res_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i && (cnt_q != '0);
  assign push_ok = push_i && ((cnt_q != FULL) || pop_ok);
  assign dout_o  = (cnt_q != '0) ? mem_q[rp_q] : '0;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (push_ok && wp_q == PW'(g))   mem_q[g] <= din_i;
    end
  end
endmodule

// File: rtl/filt_sys_regs.sv
module filt_sys_regs #(
  parameter int DW     = 16,
  parameter int SYS_AW = 2,
  localparam int NREG  = 1 << SYS_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SYS_AW-1:0] idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          reg_q[g] <= '0;
      else if (we_i && idx_i == SYS_AW'(g)) reg_q[g] <= wdata_i;
    end
  end

  assign rdata_o = reg_q[idx_i];
endmodule

// File: rtl/filt_host_regs.sv
module filt_host_regs
  import filt_hreg_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            AW        = 8,
  parameter int            DEPTH     = 4,
  parameter int            SYS_AW    = 2,
  parameter logic [AW-1:0] CHIP_BASE = 8'h40,
  parameter logic [DW-1:0] ROLE_RST  = 16'h0001,
  parameter logic [DW-1:0] VERSION   = 16'h0003,
  localparam int           CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_chip_i,
  input  logic          cs_sys_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          err_o,
  input  logic          res_push_i,
  input  logic [DW-1:0] res_data_i,
  output logic          irq_o
);
  logic [AW-1:0] off_full;
  chip_off_e     off;
  logic          chip_hit, chip_rd, chip_wr;
  logic          sys_sel, is_master, sys_wr, sys_rd_ok, sys_rd_bad;
  logic          pop, stat_rd;
  logic [DW-1:0] role_q, rd_val, fifo_dout, sys_dout;
  logic [CW-1:0] res_cnt;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q, err_q, irq_q;

  // window decode relative to base
  assign off_full  = addr_i - CHIP_BASE;
  assign chip_hit  = cs_chip_i && (off_full < AW'(4));
  assign off       = chip_off_e'(off_full[1:0]);
  assign chip_rd   = chip_hit && rd_i;
  assign chip_wr   = chip_hit && wr_i;

  assign is_master = (role_q == '0);
  assign sys_sel   = cs_sys_i && !cs_chip_i;
  assign sys_wr    = sys_sel && wr_i && is_master;
  assign sys_rd_ok = sys_sel && rd_i && is_master;
  assign sys_rd_bad = sys_sel && rd_i && !is_master;

  assign pop     = chip_rd && (off == OFF_DATA);
  assign stat_rd = chip_rd && (off == OFF_STAT);

  filt_res_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (res_push_i),
    .din_i  (res_data_i),
    .pop_i  (pop),
    .dout_o (fifo_dout),
    .cnt_o  (res_cnt)
  );

  filt_sys_regs #(.DW(DW), .SYS_AW(SYS_AW)) i_sys (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sys_wr),
    .idx_i   (addr_i[SYS_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (sys_dout)
  );

  always_comb begin
    rd_val = '0;
    if (chip_rd) begin
      unique case (off)
        OFF_STAT: rd_val = DW'(res_cnt != '0);
        OFF_DATA: rd_val = fifo_dout;
        OFF_ROLE: rd_val = role_q;
        OFF_VER:  rd_val = VERSION;
        default:  rd_val = '0;
      endcase
    end else if (sys_rd_ok) begin
      rd_val = sys_dout;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      role_q   <= ROLE_RST;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (chip_wr && off == OFF_ROLE) role_q <= wdata_i;
      rvalid_q <= chip_rd || sys_rd_ok;
      rdata_q  <= rd_val;
      err_q    <= sys_rd_bad;
      // set on push into empty wins over clear
      if (res_push_i && res_cnt == '0)    irq_q <= 1'b1;
      else if (stat_rd && res_cnt == '0)  irq_q <= 1'b0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/filt_host_regs_chk.sv
module filt_host_regs_chk #(
  parameter int            DW      = 16,
  parameter int            DEPTH   = 4,
  parameter int            CW      = 3,
  parameter logic [DW-1:0] VERSION = 16'h0003
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chip_rd_i,
  input logic [1:0]    off_i,
  input logic          sys_sel_i,
  input logic          rd_i,
  input logic [DW-1:0] role_i,
  input logic [CW-1:0] cnt_i,
  input logic          push_i,
  input logic [DW-1:0] rdata_i,
  input logic          rvalid_i,
  input logic          err_i,
  input logic          irq_i
);
  // R3
  rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_i |-> rdata_i == '0);
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));
  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rd_i && off_i == 2'd1 && cnt_i == '0) |=> (rvalid_i && rdata_i == '0));
  // R7
  version_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rd_i && off_i == 2'd3) |=> (rvalid_i && rdata_i == VERSION));
  // R8
  slave_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_sel_i && rd_i && role_i != '0) |=> (err_i && !rvalid_i));
  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i || $past(sys_sel_i && rd_i && role_i != '0));
  // R9
  master_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_sel_i && rd_i && role_i == '0) |=> (rvalid_i && !err_i));
  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_i == '0) |=> irq_i);
  // R11
  irq_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i != '0 |-> irq_i);
  // R11
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rd_i && off_i == 2'd0 && cnt_i == '0 && !push_i) |=> !irq_i);
endmodule

bind filt_host_regs filt_host_regs_chk #(
  .DW(DW), .DEPTH(DEPTH), .CW(CW), .VERSION(VERSION)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chip_rd_i (chip_rd),
  .off_i     (off_full[1:0]),
  .sys_sel_i (sys_sel),
  .rd_i      (rd_i),
  .role_i    (role_q),
  .cnt_i     (res_cnt),
  .push_i    (res_push_i),
  .rdata_i   (rdata_o),
  .rvalid_i  (rvalid_o),
  .err_i     (err_o),
  .irq_i     (irq_o)
);

// File: tb/test_filt_host_regs.sv
module test_filt_host_regs;
  localparam logic [7:0] BASE = 8'h40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_chip_i = 1'b0, cs_sys_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0, res_data_i = '0;
  logic        res_push_i = 1'b0;
  logic [15:0] rdata_o;
  logic        rvalid_o, err_o, irq_o;

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [15:0] mq[$];
  logic [15:0] m_role = 16'h0001;
  logic [15:0] m_sys [4] = '{default: '0};
  logic        m_irq = 1'b0;

  filt_host_regs i_filt_host_regs (.*);

  always #2ns clk_i = ~clk_i;

  initial begin
    #400us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stat();
    return (mq.size() != 0) ? 16'h1 : 16'h0;
  endfunction

  task automatic idle();
    cs_chip_i = 0; cs_sys_i = 0; wr_i = 0; rd_i = 0; res_push_i = 0;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk_i);
    res_push_i = 1; res_data_i = d;
    if (mq.size() == 0) m_irq = 1;
    if (mq.size() < 4) mq.push_back(d);
    @(negedge clk_i);
    idle();
    chk(irq_o == m_irq, "R10 irq after push", 16'(irq_o), 16'(m_irq));
  endtask

  task automatic wr(input bit sys, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    cs_chip_i = !sys; cs_sys_i = sys; addr_i = a; wdata_i = d; wr_i = 1;
    if (!sys && a == BASE + 2) m_role = d;
    if (sys && m_role == 0) m_sys[a[1:0]] = d;
    @(negedge clk_i);
    idle();
  endtask

  task automatic rd(input bit sys, input logic [7:0] a, output logic [15:0] d,
                    output logic v, output logic e);
    @(negedge clk_i);
    cs_chip_i = !sys; cs_sys_i = sys; addr_i = a; rd_i = 1;
    @(negedge clk_i);
    d = rdata_o; v = rvalid_o; e = err_o;
    idle();
  endtask

  // read a chip offset and compare with model
  task automatic chip_rd_chk(input int off);
    logic [15:0] d, exp; logic v, e;
    case (off)
      0: exp = exp_stat();
      1: exp = (mq.size() != 0) ? mq[0] : 16'h0;
      2: exp = m_role;
      default: exp = 16'h0003;
    endcase
    rd(0, BASE + 8'(off), d, v, e);
    if (off == 1 && mq.size() != 0) void'(mq.pop_front());
    if (off == 0 && mq.size() == 0) m_irq = 0;
    case (off)
      0: chk(d == exp && v, "R4 status", d, exp);
      1: chk(d == exp && v, "R5 result data", d, exp);
      2: chk(d == exp && v, "R6 role", d, exp);
      default: chk(d == exp && v, "R7 version", d, exp);
    endcase
    chk(!e, "R3 no err on chip read", 16'(e), 16'h0);
    chk(irq_o == m_irq, "R11 irq after read", 16'(irq_o), 16'(m_irq));
  endtask

  task automatic sys_rd_chk(input logic [7:0] a);
    logic [15:0] d; logic v, e;
    rd(1, a, d, v, e);
    if (m_role == 0) begin
      chk(d == m_sys[a[1:0]] && v && !e, "R9 master sys read", d, m_sys[a[1:0]]);
    end else begin
      chk(d == 0 && !v && e, "R8 slave sys read refused", {d[13:0], v, e}, 16'h0001);
      @(negedge clk_i);
      chk(!err_o, "R8 err one cycle", 16'(err_o), 16'h0);
    end
  endtask

  initial begin
    logic [15:0] d; logic v, e;
    void'($urandom(32'd20240611));
    #10ns;
    chk(rdata_o == 0 && !rvalid_o && !err_o && !irq_o, "R1 reset outputs",
        {rdata_o[12:0], rvalid_o, err_o, irq_o}, 16'h0);
    rst_ni = 1;
    chip_rd_chk(2);                       // R1 role resets to slave
    chip_rd_chk(0);                       // R1 empty
    // R2 outside window
    rd(0, BASE + 8'd4, d, v, e);
    chk(!v && d == 0, "R2 out of window", {d[14:0], v}, 16'h0);
    rd(0, BASE - 8'd1, d, v, e);
    chk(!v && d == 0, "R2 below window", {d[14:0], v}, 16'h0);
    // R7 writes to read-only offsets
    wr(0, BASE + 3, 16'hBEEF);
    wr(0, BASE + 0, 16'h00FF);
    wr(0, BASE + 1, 16'h1234);
    chip_rd_chk(3);
    chip_rd_chk(0);
    // R8 slave gating
    wr(1, 8'h01, 16'hAAAA);
    sys_rd_chk(8'h01);
    wr(0, BASE + 2, 16'h0000);            // R6 become master
    chip_rd_chk(2);
    sys_rd_chk(8'h01);                    // R8 earlier write was dropped
    wr(1, 8'h02, 16'h5A5A);
    sys_rd_chk(8'h02);                    // R9
    // R5 fill beyond depth
    for (int i = 0; i < 5; i++) push(16'h100 + 16'(i));
    chip_rd_chk(0);                       // R11 pending keeps irq
    for (int i = 0; i < 5; i++) chip_rd_chk(1); // last one is empty read
    chk(irq_o, "R11 irq held until status read", 16'(irq_o), 16'h1);
    chip_rd_chk(0);                       // R11 clear
    wr(0, BASE + 2, 16'h0007);            // R6 back to slave
    sys_rd_chk(8'h02);

    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom % 10);
      case (r)
        0, 1, 2: push(16'($urandom));
        3: chip_rd_chk(0);
        4, 5: chip_rd_chk(1);
        6: begin
          wr(0, BASE + 2, ($urandom % 2) ? 16'h0 : 16'($urandom % 4));
          chip_rd_chk(2 + int'($urandom % 2));
        end
        7: wr(1, 8'($urandom), 16'($urandom));
        8: sys_rd_chk(8'($urandom));
        default: begin
          rd(0, BASE + 8'd4 + 8'($urandom % 16), d, v, e);
          chk(!v && d == 0, "R2 random out of window", {d[14:0], v}, 16'h0);
        end
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule